// File: doc/BRIEF.md
# Subrow Field Copy Unit

This unit holds a small array of memory rows and moves a bit field of any length from one column position in a source row to another column position in a destination row. The source and destination may be the same row. Only the destination field changes. Every other bit of the destination row, and the whole source row, keeps its value.

A copy takes three row cycles. In the first cycle the unit reads the source row. It keeps only the source field, moves that field to the destination column and holds the result in a shift register. The source row is not changed. In the second cycle it reads the destination row, clears the destination field and keeps the rest in a buffer register. In the third cycle it writes the bitwise OR of the two registers back to the destination row.

A host port loads and reads rows when the unit is idle. Requests that cannot be served safely end at once: fields that run past the row edge, and overlapping fields in one row, are flagged as errors.

Top module: `fc_subrow_copy`

## Requirements
- R1: After reset, `busy`, `done` and `err` are all low.
- R2: A valid request with non-zero length is accepted on a clock edge where `start` is high and `busy` is low. `busy` is then high for exactly three cycles. `done` pulses high for one cycle in the cycle after `busy` falls, and `err` stays low.
- R3: After a valid copy, destination bits `dst_col+k` hold the old source bits `src_col+k`, for k from 0 to `len-1`. Bit 0 is the least significant bit of a row word.
- R4: After a valid copy, all destination bits outside the field keep their old values. A source row that differs from the destination row is left completely unchanged.
- R5: When the source row equals the destination row and the two fields do not overlap, the copy gives the result of R3 and R4. Fields that only touch, end to start, count as not overlapping.
- R6: If `col+len` is larger than the row width for either field, `done` and `err` are both high in the cycle after `start`. `busy` stays low and no row changes.
- R7: On the same row, fields that share any column are rejected in the same way as in R6.
- R8: A request with `len` equal to 0 gives `done` high with `err` low in the cycle after `start`. This holds whatever the columns are, and no row changes.
- R9: While `busy` is high, `start` and host writes are ignored. This includes a host write presented during the write-back cycle.
- R10: When idle, a host write stores `wr_data` into row `wr_row`. `rd_data` always shows the current contents of row `rd_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a field copy |
| src_row | input | RAW | Source row index |
| src_col | input | CW | Source field start column |
| dst_row | input | RAW | Destination row index |
| dst_col | input | CW | Destination field start column |
| len | input | LW | Field length in bits (0..ROW_W) |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected (valid together with done) |
| wr_en | input | 1 | Host row write enable |
| wr_row | input | RAW | Host write row index |
| wr_data | input | ROW_W | Host write data |
| rd_row | input | RAW | Host read row index |
| rd_data | output | ROW_W | Contents of row rd_row |

## Verification
Two functions can meet in one cycle: the copy engine's write-back to the destination row, and a host write to that same row. The bench provokes this by raising `wr_en` on the destination row during the third busy cycle, and also by raising a second `start` during the first busy cycle. It then reads the row back through the host port. The row must match the reference model's copy result, with the host data nowhere present. `done` must still appear in exactly the cycle that R2 predicts, with no extra pulse.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRC  = 2'd1,
    ST_DST  = 2'd2,
    ST_WR   = 2'd3
  } fc_state_e;
endpackage

// File: rtl/fc_mask_gen.sv
module fc_mask_gen #(
  parameter int ROW_W = 32,
  localparam int CW = $clog2(ROW_W),
  localparam int LW = $clog2(ROW_W + 1),
  localparam int EW = LW + 1
) (
  input  logic [CW-1:0]    col,
  input  logic [LW-1:0]    len,
  output logic [ROW_W-1:0] mask
);
  logic [EW-1:0] col_x;
  logic [EW-1:0] end_x;

  assign col_x = EW'(col);
  assign end_x = EW'(col) + EW'(len);

  for (genvar i = 0; i < ROW_W; i++) begin : g_bit
    assign mask[i] = (EW'(i) >= col_x) && (EW'(i) < end_x);
  end
endmodule

// File: rtl/fc_row_array.sv
module fc_row_array #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 32,
  localparam int RAW = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [RAW-1:0]   waddr,
  input  logic [ROW_W-1:0] wdata,
  input  logic [RAW-1:0]   raddr_a,
  output logic [ROW_W-1:0] rdata_a,
  input  logic [RAW-1:0]   raddr_b,
  output logic [ROW_W-1:0] rdata_b
);
  logic [ROW_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/fc_subrow_copy.sv
module fc_subrow_copy #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 32,
  localparam int RAW = $clog2(ROWS),
  localparam int CW  = $clog2(ROW_W),
  localparam int LW  = $clog2(ROW_W + 1),
  localparam int EW  = LW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RAW-1:0]   src_row,
  input  logic [CW-1:0]    src_col,
  input  logic [RAW-1:0]   dst_row,
  input  logic [CW-1:0]    dst_col,
  input  logic [LW-1:0]    len,
  output logic             busy,
  output logic             done,
  output logic             err,
  input  logic             wr_en,
  input  logic [RAW-1:0]   wr_row,
  input  logic [ROW_W-1:0] wr_data,
  input  logic [RAW-1:0]   rd_row,
  output logic [ROW_W-1:0] rd_data
);
  import fc_pkg::*;

  fc_state_e        state_q, state_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             req_ld;
  logic [RAW-1:0]   sr_q, dr_q;
  logic [CW-1:0]    sc_q, dc_q;
  logic [LW-1:0]    len_q;
  logic [ROW_W-1:0] shf_q, shf_d;
  logic [ROW_W-1:0] buf_q, buf_d;
  logic [ROW_W-1:0] smask, dmask;
  logic [ROW_W-1:0] eng_rdata;
  logic [RAW-1:0]   eng_raddr;
  logic             arr_we;
  logic [RAW-1:0]   arr_waddr;
  logic [ROW_W-1:0] arr_wdata;

  // request screening on the live inputs
  logic [EW-1:0] src_end, dst_end;
  logic          out_of_row, overlap, bad_req;

  assign src_end    = EW'(src_col) + EW'(len);
  assign dst_end    = EW'(dst_col) + EW'(len);
  assign out_of_row = (src_end > EW'(ROW_W)) || (dst_end > EW'(ROW_W));
  assign overlap    = (src_row == dst_row) &&
                      (EW'(src_col) < dst_end) && (EW'(dst_col) < src_end);
  assign bad_req    = out_of_row || overlap;

  fc_mask_gen #(.ROW_W(ROW_W)) u_smask (.col(sc_q), .len(len_q), .mask(smask));
  fc_mask_gen #(.ROW_W(ROW_W)) u_dmask (.col(dc_q), .len(len_q), .mask(dmask));

  assign eng_raddr = (state_q == ST_SRC) ? sr_q : dr_q;
  assign arr_we    = (state_q == ST_WR) || (wr_en && (state_q == ST_IDLE));
  assign arr_waddr = (state_q == ST_WR) ? dr_q : wr_row;
  assign arr_wdata = (state_q == ST_WR) ? (shf_q | buf_q) : wr_data;

  fc_row_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
    .clk     (clk),
    .we      (arr_we),
    .waddr   (arr_waddr),
    .wdata   (arr_wdata),
    .raddr_a (rd_row),
    .rdata_a (rd_data),
    .raddr_b (eng_raddr),
    .rdata_b (eng_rdata)
  );

  // datapath next values: isolate, align; clear destination field
  assign shf_d = ((eng_rdata & smask) >> sc_q) << dc_q;
  assign buf_d = eng_rdata & ~dmask;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    req_ld  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (len == '0) begin
            done_d = 1'b1;
          end else if (bad_req) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            state_d = ST_SRC;
            req_ld  = 1'b1;
          end
        end
      end
      ST_SRC:  state_d = ST_DST;
      ST_DST:  state_d = ST_WR;
      ST_WR: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_ld) begin
      sr_q  <= src_row;
      dr_q  <= dst_row;
      sc_q  <= src_col;
      dc_q  <= dst_col;
      len_q <= len;
    end
    if (state_q == ST_SRC) begin
      shf_q <= shf_d;
    end
    if (state_q == ST_DST) begin
      buf_q <= buf_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/fc_subrow_copy_chk.sv
module fc_subrow_copy_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             arr_we,
  input fc_pkg::fc_state_e state_q
);
  import fc_pkg::*;

  assert_three_cycles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 (!busy && done && !err));

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !busy));

  assert_reject_stays_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !busy) |=> (state_q == ST_IDLE) || $past(start));

  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && busy) |-> (state_q == ST_WR));

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state_q != ST_WR) |=> busy);
endmodule

bind fc_subrow_copy fc_subrow_copy_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .arr_we  (arr_we),
  .state_q (state_q)
);

// File: tb/tb_fc_subrow_copy.sv
module tb_fc_subrow_copy;
  localparam int ROWS  = 16;
  localparam int ROW_W = 32;
  localparam int RAW = $clog2(ROWS);
  localparam int CW  = $clog2(ROW_W);
  localparam int LW  = $clog2(ROW_W + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [RAW-1:0]   src_row, dst_row;
  logic [CW-1:0]    src_col, dst_col;
  logic [LW-1:0]    len;
  logic             busy, done, err;
  logic             wr_en;
  logic [RAW-1:0]   wr_row;
  logic [ROW_W-1:0] wr_data;
  logic [RAW-1:0]   rd_row;
  logic [ROW_W-1:0] rd_data;

  logic [ROW_W-1:0] model [ROWS];
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fc_subrow_copy #(.ROWS(ROWS), .ROW_W(ROW_W)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [ROW_W-1:0] act,
                     input logic [ROW_W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int r, input logic [ROW_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_row = RAW'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[r] = d;
  endtask

  task automatic check_row(input int r, input string tag);
    rd_row = RAW'(r);
    #1;
    chk(rd_data === model[r], tag, rd_data, model[r]);
  endtask

  // 0 = valid copy, 1 = zero length, 2 = rejected
  function automatic int classify(input int sr, input int sc, input int dr,
                                  input int dc, input int ln);
    if (ln == 0) return 1;
    if (sc + ln > ROW_W || dc + ln > ROW_W) return 2;
    if (sr == dr && sc < dc + ln && dc < sc + ln) return 2;
    return 0;
  endfunction

  // inj: 0 none, 1 start during first busy cycle, 2 host write during write-back
  task automatic do_copy(input int sr, input int sc, input int dr, input int dc,
                         input int ln, input int inj);
    int kind;
    logic [ROW_W-1:0] old_src;
    kind = classify(sr, sc, dr, dc, ln);
    @(negedge clk);
    start = 1'b1;
    src_row = RAW'(sr); src_col = CW'(sc);
    dst_row = RAW'(dr); dst_col = CW'(dc); len = LW'(ln);
    @(negedge clk);
    start = 1'b0;
    if (kind != 0) begin
      chk(done === 1'b1, "R6/R7/R8 done next cycle", {31'd0, done}, 1);
      chk(err === (kind == 2), kind == 2 ? "R6/R7 err set" : "R8 err clear",
          {31'd0, err}, {31'd0, kind == 2});
      chk(busy === 1'b0, "R6 busy low", {31'd0, busy}, 0);
    end else begin
      old_src = model[sr];
      chk(busy === 1'b1 && done === 1'b0, "R2 busy cycle 1", {30'd0, busy, done}, 2);
      if (inj == 1) begin
        start = 1'b1; len = '0; src_col = '0; dst_col = '0;
      end
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, "R2 busy cycle 2 R9", {30'd0, busy, done}, 2);
      @(negedge clk);
      chk(busy === 1'b1 && done === 1'b0, "R2 busy cycle 3", {30'd0, busy, done}, 2);
      if (inj == 2) begin
        wr_en = 1'b1; wr_row = RAW'(dr); wr_data = ~model[dr];
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk(done === 1'b1 && err === 1'b0 && busy === 1'b0, "R2 done after three",
          {29'd0, done, err, busy}, 4);
      for (int k = 0; k < ln; k++) model[dr][dc + k] = old_src[sc + k];
      @(negedge clk);
      chk(done === 1'b0, "R2 done single pulse", {31'd0, done}, 0);
    end
    check_row(dr, "R3/R4/R5/R9 destination row");
    check_row(sr, "R4 source row");
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0;
    src_row = '0; dst_row = '0; src_col = '0; dst_col = '0; len = '0;
    wr_row = '0; wr_data = '0; rd_row = '0;
    #9;
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 reset outputs",
        {29'd0, busy, done, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < ROWS; r++) host_wr(r, $urandom());
    for (int r = 0; r < ROWS; r++) check_row(r, "R10 host load");

    do_copy(1, 0, 2, 0, 32, 0);     // R3 whole row
    do_copy(3, 5, 4, 20, 9, 0);     // R3 R4 shift up
    do_copy(5, 23, 6, 0, 9, 0);     // R3 shift down
    do_copy(7, 31, 8, 0, 1, 0);     // R3 single bit edge
    do_copy(9, 0, 9, 16, 16, 0);    // R5 same row, touching halves
    do_copy(10, 20, 10, 4, 8, 0);   // R5 same row apart
    do_copy(11, 4, 11, 8, 8, 0);    // R7 overlap
    do_copy(11, 25, 12, 0, 8, 0);   // R6 source past edge
    do_copy(11, 0, 12, 30, 3, 0);   // R6 destination past edge
    do_copy(13, 31, 14, 31, 0, 0);  // R8 zero length
    do_copy(13, 2, 14, 7, 6, 1);    // R9 start while busy
    do_copy(15, 10, 0, 12, 11, 2);  // R9 host write in write-back cycle

    for (int it = 0; it < 150; it++) begin
      int sr, dr, sc, dc, ln;
      sr = $urandom_range(ROWS - 1);
      dr = ($urandom_range(3) == 0) ? sr : $urandom_range(ROWS - 1);
      sc = $urandom_range(ROW_W - 1);
      dc = $urandom_range(ROW_W - 1);
      ln = ($urandom_range(9) == 0) ? 0 : $urandom_range(16, 1);
      do_copy(sr, sc, dr, dc, ln, $urandom_range(2));
      if (it % 25 == 0) host_wr($urandom_range(ROWS - 1), $urandom());
    end
    for (int r = 0; r < ROWS; r++) check_row(r, "R4 final array");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule